// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a 24-bit periodic tick timer for a processor subsystem. Software programs a reload value, then sets an enable bit. The counter loads that value and counts down by one on each counting tick. A counting tick is either every core clock cycle or each cycle on which an external reference-tick enable is high; a control bit picks which. After the count reaches zero, the next counting tick ends the period. The counter then reloads, a sticky count flag is set, and, if interrupts are allowed, a one-cycle request goes to the interrupt controller.

Access is through a plain synchronous register port with four word registers: control/status, reload, current count and calibration. A write to the current-count register restarts the period. Reading the control register clears the sticky flag. A reload value of zero gives a one-shot: the timer turns itself off when that single period ends.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control, reload and current-count registers read 0, and `tick_irq_o` is low.
- R2: Writing control (word offset 0x0) changes only bit 0 (enable), bit 1 (interrupt allow) and bit 2 (clock select). Bit 16 (count flag) cannot be written. All other control bits read 0.
- R3: A read of control with `acc_rd_i` high returns the value before the access and clears the count flag at that clock edge. A wrap in the same cycle wins and leaves the flag set. With `acc_rd_i` low, `acc_rdata_o` still shows the addressed register but nothing is cleared.
- R4: When enable goes from 0 to 1, the count loads from reload at that edge. While enable is 0 the count does not change. The current register (offset 0x8) reads 0 while enable is 0.
- R5: A period lasts reload+1 counting ticks. The tick that finds the count at 0 reloads the count and sets the count flag.
- R6: At the edge that ends a period, `tick_irq_o` goes high for exactly one cycle, and only if interrupt allow is 1.
- R7: If reload is 0 when a period ends, enable clears at that edge.
- R8: Any write to the current register (offset 0x8) reloads the count from reload while enabled and clears the count flag. The written data has no effect.
- R9: The calibration register (offset 0xC) always reads 10000 (decimal), and writes to it have no effect.
- R10: Changing the clock select bit while enabled reloads the count at that write edge.
- R11: With clock select 1, the count steps every clock cycle. With clock select 0, it steps only on cycles where `ref_tick_i` is high.
- R12: The reload register (offset 0x4) stores the low 24 bits of the written data. Its bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference-tick enable, used when clock select is 0 |
| acc_wr_i | input | 1 | Register write strobe |
| acc_rd_i | input | 1 | Register read strobe; enables the read side effect |
| acc_addr_i | input | ADDR_W (4) | Byte address; bits 3:2 select the word |
| acc_wdata_i | input | DATA_W (32) | Write data |
| acc_rdata_o | output | DATA_W (32) | Read data for the addressed register, combinational |
| tick_irq_o | output | 1 | One-cycle interrupt request at the end of a period |

## Verification
Read data is combinational, so the bench looks at it in the same half cycle as the address. Register writes, loads and count steps show up after the first rising edge that follows the stimulus. The bench drives on falling edges and samples one falling edge later, after exactly that one rising edge. After an enable with reload R on the core clock, the count reads R. It reads 0 after R more edges. After edge R+1 the interrupt and the flag are both visible, and the interrupt is gone again one edge later. Each task counts edges in this way before it checks, and the read-clear is tested by sampling during the read and once more after its edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // word selector, taken from byte address bits [3:2]
   typedef enum logic [1:0] {
      WSEL_CTRL   = 2'd0,
      WSEL_RELOAD = 2'd1,
      WSEL_COUNT  = 2'd2,
      WSEL_CALIB  = 2'd3
   } tick_wsel_e;

   localparam int unsigned CTRL_EN_BIT     = 0;
   localparam int unsigned CTRL_IRQEN_BIT  = 1;
   localparam int unsigned CTRL_CLKSEL_BIT = 2;
   localparam int unsigned CTRL_FLAG_BIT   = 16;

   localparam int unsigned CTRL_WR_BITS    = 3;
   localparam int unsigned CALIB_DEFAULT   = 10000;

endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_ctrl_i,
   input  logic             wr_reload_i,
   input  logic             wr_count_i,
   input  logic             rd_ctrl_i,
   input  logic [CTRL_WR_BITS-1:0] ctrl_wdata_i,
   input  logic [CNT_W-1:0] reload_wdata_i,
   input  logic             wrap_i,
   output logic             en_o,
   output logic             irqen_o,
   output logic             clksel_o,
   output logic             flag_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             load_o
);

   logic             en_q, irqen_q, clksel_q, flag_q;
   logic [CNT_W-1:0] reload_q;
   logic             auto_off;
   logic             en_rise, sel_change;

   assign auto_off   = wrap_i && (reload_q == '0);
   assign en_rise    = wr_ctrl_i && ctrl_wdata_i[CTRL_EN_BIT] && !en_q;
   assign sel_change = wr_ctrl_i && ctrl_wdata_i[CTRL_EN_BIT] && en_q &&
                       (ctrl_wdata_i[CTRL_CLKSEL_BIT] != clksel_q);
   assign load_o     = en_rise || sel_change || (wr_count_i && en_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q     <= 1'b0;
         irqen_q  <= 1'b0;
         clksel_q <= 1'b0;
      end else if (wr_ctrl_i) begin
         en_q     <= ctrl_wdata_i[CTRL_EN_BIT];
         irqen_q  <= ctrl_wdata_i[CTRL_IRQEN_BIT];
         clksel_q <= ctrl_wdata_i[CTRL_CLKSEL_BIT];
      end else if (auto_off) begin
         en_q     <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (wrap_i) begin
         flag_q <= 1'b1;
      end else if (rd_ctrl_i || wr_count_i) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
      end else if (wr_reload_i) begin
         reload_q <= reload_wdata_i;
      end
   end

   assign en_o     = en_q;
   assign irqen_o  = irqen_q;
   assign clksel_o = clksel_q;
   assign flag_o   = flag_q;
   assign reload_o = reload_q;

   // R5: a wrap always leaves the flag set
   p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i |=> flag_q);

   // R3: a side-effect read of control clears the flag unless a wrap coincides
   p_flag_rdclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ctrl_i && !wrap_i) |=> !flag_q);

   // R8: a write to the count register clears the flag
   p_flag_wrclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_count_i && !wrap_i) |=> !flag_q);

   // R7: one-shot mode turns the timer off at the end of its period
   p_auto_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i && (reload_q == '0) && !wr_ctrl_i) |=> !en_q);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned CNT_W   = 24,
   parameter bit          HAS_REF = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_tick_i,
   input  logic             en_i,
   input  logic             clksel_i,
   input  logic             irqen_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o,
   output logic             irq_o
);

   logic             step;
   logic [CNT_W-1:0] count_q;
   logic             irq_q;

   generate
      if (HAS_REF) begin : g_ref_source
         assign step = en_i && (clksel_i || ref_tick_i);
      end else begin : g_core_only
         logic unused_ref;
         assign unused_ref = ref_tick_i ^ clksel_i;
         assign step = en_i;
      end
   endgenerate

   assign wrap_o = step && !load_i && (count_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= reload_i;
      end else if (step) begin
         if (count_q == '0) begin
            count_q <= reload_i;
         end else begin
            count_q <= count_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= wrap_o && irqen_i;
      end
   end

   assign count_o = count_q;
   assign irq_o   = irq_q;

   // R6: the request never lasts two cycles
   p_irq_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q);

   // R4: a load takes the reload value
   p_load_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (count_q == $past(reload_i)));

   // R4: a disabled counter holds its value
   p_hold_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !load_i) |=> $stable(count_q));

endmodule

// File: rtl/tick_rd_mux.sv
module tick_rd_mux
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CAL_VALUE = CALIB_DEFAULT
) (
   input  logic              hit_i,
   input  tick_wsel_e        wsel_i,
   input  logic              en_i,
   input  logic              irqen_i,
   input  logic              clksel_i,
   input  logic              flag_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word                  = '0;
      ctrl_word[CTRL_EN_BIT]     = en_i;
      ctrl_word[CTRL_IRQEN_BIT]  = irqen_i;
      ctrl_word[CTRL_CLKSEL_BIT] = clksel_i;
      ctrl_word[CTRL_FLAG_BIT]   = flag_i;
   end

   always_comb begin
      rdata_o = '0;
      if (hit_i) begin
         unique case (wsel_i)
            WSEL_CTRL:   rdata_o = ctrl_word;
            WSEL_RELOAD: rdata_o = DATA_W'(reload_i);
            WSEL_COUNT:  rdata_o = en_i ? DATA_W'(count_i) : '0;
            WSEL_CALIB:  rdata_o = DATA_W'(CAL_VALUE);
            default:     rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CAL_VALUE = CALIB_DEFAULT,
   parameter bit          HAS_REF   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_tick_i,
   input  logic              acc_wr_i,
   input  logic              acc_rd_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [DATA_W-1:0] acc_wdata_i,
   output logic [DATA_W-1:0] acc_rdata_o,
   output logic              tick_irq_o
);

   localparam int unsigned WSEL_LSB = 2;
   localparam int unsigned WSEL_MSB = WSEL_LSB + 1;

   initial begin
      assert (DATA_W > CTRL_FLAG_BIT && CNT_W <= DATA_W && CNT_W >= 2)
         else $error("sys_tick_timer: CNT_W/DATA_W out of range");
      assert (ADDR_W >= WSEL_MSB + 1)
         else $error("sys_tick_timer: ADDR_W too small");
      assert (DATA_W >= 32 || CAL_VALUE < (1 << DATA_W))
         else $error("sys_tick_timer: CAL_VALUE does not fit");
   end

   logic       hit;
   tick_wsel_e wsel;
   logic       wr_ctrl, wr_reload, wr_count, rd_ctrl;

   generate
      if (ADDR_W > WSEL_MSB + 1) begin : g_upper_decode
         assign hit = (acc_addr_i[ADDR_W-1:WSEL_MSB+1] == '0);
      end else begin : g_no_upper
         assign hit = 1'b1;
      end
   endgenerate

   assign wsel      = tick_wsel_e'(acc_addr_i[WSEL_MSB:WSEL_LSB]);
   assign wr_ctrl   = acc_wr_i && hit && (wsel == WSEL_CTRL);
   assign wr_reload = acc_wr_i && hit && (wsel == WSEL_RELOAD);
   assign wr_count  = acc_wr_i && hit && (wsel == WSEL_COUNT);
   assign rd_ctrl   = acc_rd_i && hit && (wsel == WSEL_CTRL);

   logic unused_bits;
   assign unused_bits = ^{acc_addr_i[WSEL_LSB-1:0], acc_wdata_i};

   logic             en, irqen, clksel, flag, load, wrap;
   logic [CNT_W-1:0] reload, count;

   tick_ctrl_regs #(
      .CNT_W (CNT_W)
   ) i_regs (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_ctrl_i      (wr_ctrl),
      .wr_reload_i    (wr_reload),
      .wr_count_i     (wr_count),
      .rd_ctrl_i      (rd_ctrl),
      .ctrl_wdata_i   (acc_wdata_i[CTRL_WR_BITS-1:0]),
      .reload_wdata_i (acc_wdata_i[CNT_W-1:0]),
      .wrap_i         (wrap),
      .en_o           (en),
      .irqen_o        (irqen),
      .clksel_o       (clksel),
      .flag_o         (flag),
      .reload_o       (reload),
      .load_o         (load)
   );

   tick_counter #(
      .CNT_W   (CNT_W),
      .HAS_REF (HAS_REF)
   ) i_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_tick_i (ref_tick_i),
      .en_i       (en),
      .clksel_i   (clksel),
      .irqen_i    (irqen),
      .load_i     (load),
      .reload_i   (reload),
      .count_o    (count),
      .wrap_o     (wrap),
      .irq_o      (tick_irq_o)
   );

   tick_rd_mux #(
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W),
      .CAL_VALUE (CAL_VALUE)
   ) i_rmux (
      .hit_i    (hit),
      .wsel_i   (wsel),
      .en_i     (en),
      .irqen_i  (irqen),
      .clksel_i (clksel),
      .flag_i   (flag),
      .reload_i (reload),
      .count_i  (count),
      .rdata_o  (acc_rdata_o)
   );

   // R6: a request only follows a rising flag or a set flag
   p_irq_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_irq_o |-> flag);

endmodule

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned WDOG_CYC   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sys_tick_timer i_sys_tick_timer (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ref_tick_i  (ref_tick),
      .acc_wr_i    (wr),
      .acc_rd_i    (rd),
      .acc_addr_i  (addr),
      .acc_wdata_i (wdata),
      .acc_rdata_o (rdata),
      .tick_irq_o  (irq)
   );

   localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] v);
      addr = a; rd = 1'b0;
      #1 v = rdata;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      peek(A_CTRL, v); chk("R1 ctrl", v, 0);
      peek(A_RLD, v);  chk("R1 reload", v, 0);
      peek(A_CUR, v);  chk("R1 count", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      peek(A_CAL, v);  chk("R9 calib", v, 32'd10000);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr_reg(A_CTRL, 32'hFFFF_FFF8);
      peek(A_CTRL, v); chk("R2 upper bits ignored", v, 0);
      wr_reg(A_CTRL, 32'h0001_0006);
      peek(A_CTRL, v); chk("R2 flag not writable", v, 32'h6);
      wr_reg(A_CTRL, 0);
      wr_reg(A_RLD, 32'hABCD_EF12);
      peek(A_RLD, v);  chk("R12 reload width", v, 32'h00CD_EF12);
      wr_reg(A_CAL, 0);
      peek(A_CAL, v);  chk("R9 calib write ignored", v, 32'd10000);
   endtask

   task automatic t_period;
      logic [31:0] v;
      wr_reg(A_RLD, 5);
      wr_reg(A_CTRL, 7);
      peek(A_CUR, v); chk("R4 load on enable", v, 5);
      step(5);
      peek(A_CUR, v); chk("R5 count at zero", v, 0);
      chk("R6 no irq before wrap", {31'b0, irq}, 0);
      step(1);
      chk("R6 irq at wrap", {31'b0, irq}, 1);
      peek(A_CTRL, v); chk("R5 flag set", v, 32'h0001_0007);
      peek(A_CUR, v);  chk("R5 reload at wrap", v, 5);
      peek(A_CTRL, v); chk("R3 peek does not clear", v, 32'h0001_0007);
      step(1);
      chk("R6 irq one cycle", {31'b0, irq}, 0);
      rd_reg(A_CTRL, v); chk("R3 read returns flag", v, 32'h0001_0007);
      peek(A_CTRL, v);   chk("R3 flag cleared by read", v, 32'h7);
      wr_reg(A_CTRL, 0);
   endtask

   task automatic t_no_irq;
      logic [31:0] v;
      wr_reg(A_RLD, 2);
      wr_reg(A_CTRL, 5);
      step(3);
      chk("R6 no irq when not allowed", {31'b0, irq}, 0);
      peek(A_CTRL, v); chk("R5 flag without irq", v, 32'h0001_0005);
      wr_reg(A_CTRL, 0);
      peek(A_CUR, v); chk("R4 count reads 0 when off", v, 0);
      step(4);
      wr_reg(A_CTRL, 1);
      peek(A_CUR, v); chk("R4 reload on re-enable", v, 2);
      wr_reg(A_CTRL, 0);
      rd_reg(A_CTRL, v);
   endtask

   task automatic t_count_write;
      logic [31:0] v;
      wr_reg(A_RLD, 3);
      wr_reg(A_CTRL, 5);
      step(4);
      peek(A_CTRL, v); chk("R5 flag after 4 ticks", v, 32'h0001_0005);
      step(2);
      peek(A_CUR, v); chk("R5 decrement", v, 1);
      wr_reg(A_CUR, 32'h00FF_FFFF);
      peek(A_CUR, v);  chk("R8 count write reloads", v, 3);
      peek(A_CTRL, v); chk("R8 count write clears flag", v, 32'h5);
      wr_reg(A_CTRL, 0);
   endtask

   task automatic t_ref_and_switch;
      logic [31:0] v;
      wr_reg(A_RLD, 4);
      wr_reg(A_CTRL, 3);
      step(3);
      peek(A_CUR, v); chk("R11 no step without ref", v, 4);
      ref_tick = 1'b1; step(1); ref_tick = 1'b0;
      peek(A_CUR, v); chk("R11 step on ref", v, 3);
      wr_reg(A_CTRL, 7);
      peek(A_CUR, v); chk("R10 reload on select change", v, 4);
      step(2);
      peek(A_CUR, v); chk("R11 step every cycle", v, 2);
      wr_reg(A_CTRL, 0);
   endtask

   task automatic t_one_shot;
      logic [31:0] v;
      wr_reg(A_RLD, 0);
      rd_reg(A_CTRL, v);
      wr_reg(A_CTRL, 7);
      peek(A_CTRL, v); chk("R7 running", v, 32'h7);
      step(1);
      chk("R7 irq on single wrap", {31'b0, irq}, 1);
      peek(A_CTRL, v); chk("R7 enable cleared", v, 32'h0001_0006);
      step(3);
      peek(A_CTRL, v); chk("R7 stays off", v, 32'h0001_0006);
      chk("R7 no further irq", {31'b0, irq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_period();
      t_no_irq();
      t_count_write();
      t_ref_and_switch();
      t_one_shot();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end

endmodule